// File: doc/BRIEF.md
# Staged Power-On Reset Sequencer

This block turns one active-low board reset into four staged internal reset controls for a small system-on-chip. One control is a reset for the on-chip interconnect, timed by the bus clock. The other three go to the processor side and are timed by the processor master clock: a clock-setup strobe, an active-low cold reset and an active-low hot reset. All four assert at once, with no clock needed, as soon as the board reset goes low. Each one then releases on its own clock after a fixed number of cycles.

Each clock domain has its own synchronizer, which brings the release of the board reset into that domain. Each domain also has its own saturating counter, which starts once the synchronized release is seen. Comparators on the counter decide when each output lets go. On the processor side the three controls release in a fixed order with gaps between them: the clock-setup strobe first, then cold reset, then hot reset. The bus reset releases on its own schedule in the other domain. A new low pulse on the board reset at any point puts every output back into reset and restarts the counts.

Top module: `rst_stager`

## Requirements
- R1: While `ext_rst_n` is low, `bus_rst_o` is 1, `cpu_clkcfg_o` is 1, `cpu_cold_rst_n` is 0 and `cpu_hot_rst_n` is 0. The outputs take these values as soon as `ext_rst_n` falls, without waiting for a clock edge.
- R2: After `ext_rst_n` rises, `bus_rst_o` drops to 0 on bus clock rising edge number SYNC_STAGES+BUS_HOLD, counted from the first edge after the rise. With the defaults this is edge 6: 2 synchronizer cycles plus 4 cycles.
- R3: `cpu_clkcfg_o` drops to 0 on processor clock rising edge number SYNC_STAGES+CFG_HOLD after the rise. With the defaults this is edge 4.
- R4: `cpu_cold_rst_n` rises to 1 on processor clock edge number SYNC_STAGES+COLD_HOLD after the rise. With the defaults this is edge 18.
- R5: `cpu_hot_rst_n` rises HOT_GAP processor clock edges after `cpu_cold_rst_n` rises. With the defaults this is edge 34 after the rise of `ext_rst_n`.
- R6: While `ext_rst_n` stays high, cold reset never releases before the clock-setup strobe has dropped, hot reset never releases before cold reset, and no output that has released goes back into reset.
- R7: A low pulse on `ext_rst_n` during any release count puts all four outputs back into reset at once. The next rise of `ext_rst_n` starts every count again from zero.
- R8: From power-up, all four outputs stay in reset for as long as `ext_rst_n` has not yet risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Interconnect clock |
| cpu_clk | input | 1 | Processor master clock |
| ext_rst_n | input | 1 | Board reset, active low, asynchronous |
| bus_rst_o | output | 1 | Interconnect reset, active high |
| cpu_clkcfg_o | output | 1 | Clock-setup strobe, active high |
| cpu_cold_rst_n | output | 1 | Processor cold reset, active low |
| cpu_hot_rst_n | output | 1 | Processor hot reset, active low |

## Verification
The bench builds the block with its default values: SYNC_STAGES=2, BUS_HOLD=4, CFG_HOLD=2, COLD_HOLD=16 and HOT_GAP=16. With these, the last release lands on processor edge 34. Every release can therefore be checked edge by edge inside a 40-cycle window, which covers both the cycle before each release and the cycle of the release itself. The two clocks have periods of 20 ns and 14 ns and never share an edge. The board reset is released between edges, so each domain's count is measured against its own synchronized release. Reset pulses cut off mid-count, and bursts of back-to-back short pulses, show that every count restarts from zero.

// File: rtl/rst_stager.sv
module rst_stager #(
  parameter int SYNC_STAGES = 2,
  parameter int BUS_HOLD    = 4,
  parameter int CFG_HOLD    = 2,
  parameter int COLD_HOLD   = 16,
  parameter int HOT_GAP     = 16
) (
  input  logic bus_clk,
  input  logic cpu_clk,
  input  logic ext_rst_n,
  output logic bus_rst_o,
  output logic cpu_clkcfg_o,
  output logic cpu_cold_rst_n,
  output logic cpu_hot_rst_n
);

  localparam int BUS_LAST = BUS_HOLD;
  localparam int CPU_LAST = COLD_HOLD + HOT_GAP;
  localparam int BUS_W    = $clog2(BUS_LAST + 1);
  localparam int CPU_W    = $clog2(CPU_LAST + 1);
  localparam logic [BUS_W-1:0] BUS_END  = BUS_W'(BUS_LAST);
  localparam logic [CPU_W-1:0] CPU_END  = CPU_W'(CPU_LAST);
  localparam logic [BUS_W-1:0] BUS_TRIP = BUS_W'(BUS_HOLD - 1);
  localparam logic [CPU_W-1:0] CFG_TRIP = CPU_W'(CFG_HOLD - 1);
  localparam logic [CPU_W-1:0] CLD_TRIP = CPU_W'(COLD_HOLD - 1);
  localparam logic [CPU_W-1:0] HOT_TRIP = CPU_W'(CPU_LAST - 1);

  logic [SYNC_STAGES-1:0] bus_sync = '0;
  logic [SYNC_STAGES-1:0] cpu_sync = '0;
  logic [BUS_W-1:0]       bus_cnt  = '0;
  logic [CPU_W-1:0]       cpu_cnt  = '0;
  logic bus_rst_q  = 1'b1;
  logic cfg_q      = 1'b1;
  logic cold_n_q   = 1'b0;
  logic hot_n_q    = 1'b0;

  wire bus_go = bus_sync[SYNC_STAGES-1];
  wire cpu_go = cpu_sync[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES > 1) begin : g_shift
      always_ff @(posedge bus_clk or negedge ext_rst_n)
        if (!ext_rst_n) bus_sync <= '0;
        else            bus_sync <= {bus_sync[SYNC_STAGES-2:0], 1'b1};
      always_ff @(posedge cpu_clk or negedge ext_rst_n)
        if (!ext_rst_n) cpu_sync <= '0;
        else            cpu_sync <= {cpu_sync[SYNC_STAGES-2:0], 1'b1};
    end else begin : g_single
      always_ff @(posedge bus_clk or negedge ext_rst_n)
        if (!ext_rst_n) bus_sync <= '0;
        else            bus_sync <= 1'b1;
      always_ff @(posedge cpu_clk or negedge ext_rst_n)
        if (!ext_rst_n) cpu_sync <= '0;
        else            cpu_sync <= 1'b1;
    end
  endgenerate

  // bus domain: count from synchronized release, saturate at the last trip
  always_ff @(posedge bus_clk or negedge ext_rst_n)
    if (!ext_rst_n) begin
      bus_cnt   <= '0;
      bus_rst_q <= 1'b1;
    end else begin
      if (bus_go && bus_cnt != BUS_END) bus_cnt <= bus_cnt + 1'b1;
      bus_rst_q <= !(bus_go && bus_cnt >= BUS_TRIP);
    end

  // processor domain: one counter, three trip points
  always_ff @(posedge cpu_clk or negedge ext_rst_n)
    if (!ext_rst_n) begin
      cpu_cnt  <= '0;
      cfg_q    <= 1'b1;
      cold_n_q <= 1'b0;
      hot_n_q  <= 1'b0;
    end else begin
      if (cpu_go && cpu_cnt != CPU_END) cpu_cnt <= cpu_cnt + 1'b1;
      cfg_q    <= !(cpu_go && cpu_cnt >= CFG_TRIP);
      cold_n_q <=   cpu_go && cpu_cnt >= CLD_TRIP;
      hot_n_q  <=   cpu_go && cpu_cnt >= HOT_TRIP;
    end

  assign bus_rst_o      = bus_rst_q;
  assign cpu_clkcfg_o   = cfg_q;
  assign cpu_cold_rst_n = cold_n_q;
  assign cpu_hot_rst_n  = hot_n_q;

  p_held_r1: assert property (@(posedge cpu_clk)
    !ext_rst_n |-> (cfg_q && !cold_n_q && !hot_n_q));
  p_bus_held_r1: assert property (@(posedge bus_clk)
    !ext_rst_n |-> bus_rst_q);
  p_bus_point_r2: assert property (@(posedge bus_clk) disable iff (!ext_rst_n)
    $fell(bus_rst_q) |-> bus_cnt == BUS_W'(BUS_HOLD));
  p_cfg_point_r3: assert property (@(posedge cpu_clk) disable iff (!ext_rst_n)
    $fell(cfg_q) |-> cpu_cnt == CPU_W'(CFG_HOLD));
  p_cold_point_r4: assert property (@(posedge cpu_clk) disable iff (!ext_rst_n)
    $rose(cold_n_q) |-> cpu_cnt == CPU_W'(COLD_HOLD));
  p_hot_point_r5: assert property (@(posedge cpu_clk) disable iff (!ext_rst_n)
    $rose(hot_n_q) |-> cpu_cnt == CPU_END);
  p_order_cold_r6: assert property (@(posedge cpu_clk) disable iff (!ext_rst_n)
    cold_n_q |-> !cfg_q);
  p_order_hot_r6: assert property (@(posedge cpu_clk) disable iff (!ext_rst_n)
    hot_n_q |-> cold_n_q);
  p_hot_sticky_r6: assert property (@(posedge cpu_clk) disable iff (!ext_rst_n)
    hot_n_q |=> hot_n_q);
  p_bus_sticky_r6: assert property (@(posedge bus_clk) disable iff (!ext_rst_n)
    !bus_rst_q |=> !bus_rst_q);

endmodule

// File: tb/rst_stager_test.sv
module rst_stager_test;
  localparam int SYNC = 2, BUSH = 4, CFGH = 2, COLDH = 16, HOTG = 16;
  localparam int E_BUS  = SYNC + BUSH;
  localparam int E_CFG  = SYNC + CFGH;
  localparam int E_COLD = SYNC + COLDH;
  localparam int E_HOT  = E_COLD + HOTG;

  logic cpu_clk = 0, bus_clk = 0, ext_rst_n = 0;
  logic bus_rst_o, cpu_clkcfg_o, cpu_cold_rst_n, cpu_hot_rst_n;
  int vecs = 0, errs = 0;
  bit done = 0;

  always #10 cpu_clk = ~cpu_clk;
  always #7  bus_clk = ~bus_clk;

  rst_stager #(.SYNC_STAGES(SYNC), .BUS_HOLD(BUSH), .CFG_HOLD(CFGH),
               .COLD_HOLD(COLDH), .HOT_GAP(HOTG)) uut (
    .bus_clk(bus_clk), .cpu_clk(cpu_clk), .ext_rst_n(ext_rst_n),
    .bus_rst_o(bus_rst_o), .cpu_clkcfg_o(cpu_clkcfg_o),
    .cpu_cold_rst_n(cpu_cold_rst_n), .cpu_hot_rst_n(cpu_hot_rst_n));

  task automatic chk(string req, logic act, logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic chk_all_held(string req);
    chk({req, " bus"},  bus_rst_o,      1'b1);
    chk({req, " cfg"},  cpu_clkcfg_o,   1'b1);
    chk({req, " cold"}, cpu_cold_rst_n, 1'b0);
    chk({req, " hot"},  cpu_hot_rst_n,  1'b0);
  endtask

  // release between edges (cpu edge + 4 ns never meets a bus rising edge)
  task automatic release_rst();
    @(posedge cpu_clk); #4;
    ext_rst_n = 1;
  endtask

  task automatic watch_cpu(int n);
    for (int k = 1; k <= n; k++) begin
      @(posedge cpu_clk); @(negedge cpu_clk);
      chk("R3 cfg",  cpu_clkcfg_o,   k < E_CFG);
      chk("R4 cold", cpu_cold_rst_n, k >= E_COLD);
      chk("R5 hot",  cpu_hot_rst_n,  k >= E_HOT);
      if (cpu_hot_rst_n) chk("R6 order", cpu_cold_rst_n & ~cpu_clkcfg_o, 1'b1);
    end
  endtask

  task automatic watch_bus(int n);
    for (int k = 1; k <= n; k++) begin
      @(posedge bus_clk); @(negedge bus_clk);
      chk("R2 bus", bus_rst_o, k < E_BUS);
    end
  endtask

  task automatic t_powerup();
    #3 chk_all_held("R8 t0");
    repeat (5) @(posedge cpu_clk);
    #3 chk_all_held("R8 held");
  endtask

  task automatic t_full_release();
    release_rst();
    fork
      watch_cpu(E_HOT + 6);
      watch_bus(E_BUS + 6);
    join
    repeat (10) @(posedge cpu_clk);
    #3;
    chk("R6 stay hot", cpu_hot_rst_n, 1'b1);
    chk("R6 stay bus", bus_rst_o, 1'b0);
  endtask

  task automatic t_assert_now();
    @(posedge cpu_clk); #5;
    ext_rst_n = 0;
    #1 chk_all_held("R1 async");
    repeat (3) @(posedge cpu_clk);
    #2 chk_all_held("R1 held");
  endtask

  task automatic t_abort(int cyc);
    release_rst();
    repeat (cyc) @(posedge cpu_clk);
    #5 ext_rst_n = 0;
    #1 chk_all_held("R7 abort");
    repeat (2) @(posedge cpu_clk);
    t_full_release();
  endtask

  task automatic t_burst();
    for (int i = 0; i < 4; i++) begin
      release_rst();
      repeat (1 + i) @(posedge cpu_clk);
      #5 ext_rst_n = 0;
      #1 chk_all_held("R7 burst");
      @(posedge cpu_clk);
    end
    t_full_release();
  endtask

  initial begin
    t_powerup();
    t_full_release();
    t_assert_now();
    t_abort(3);
    t_assert_now();
    t_abort(20);
    t_assert_now();
    t_abort(E_HOT - 2);
    t_assert_now();
    t_burst();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule